// File: doc/BRIEF.md
# System Control Register File with Privilege Gating

This block is a small register file that sits next to a processor core and answers the core's system-control register accesses. Each access names one register through four coordinate fields: a 4-bit major number, a 3-bit first opcode, a 4-bit minor number and a 3-bit second opcode. All four fields must match. A read port returns data in the same cycle. A write port commits on the clock edge.

The block holds these kinds of register:
- Read-only identification words, supplied by a parameter table.
- Read/write registers: control, translation base, fault, lockdown, remap, thread-ID and performance-monitor settings.
- Command coordinates. A write to one of these does not store anything. It raises a one-cycle pulse for a cache maintenance, TLB maintenance or barrier/prefetch-flush operation.

Access is decided per coordinate and per privilege level. User mode reaches only a short list of coordinates: thread ID and barriers. Any access that is denied, or that matches no coordinate, reads as zero and raises the `unimpl` flag. It does not fault.

Top module: `sysctl_regfile`

## Requirements
- R1: Synchronous active-high reset clears every read/write register to zero and drives all three command pulses low.
- R2: A coordinate matches only when all four fields match. Changing any one field of a valid coordinate (for example, first opcode 1 instead of 0) gives a read of zero with `unimpl` high, and a write that is ignored with `unimpl` high.
- R3: With `priv` low, reads succeed only at (major 13, op1 0, minor 0, op2 2) and (13,0,0,3). The first returns the user read/write thread ID. The second returns the parameter `URO_VALUE`. Every other user read returns zero with `unimpl` high.
- R4: With `priv` low, writes take effect only at four coordinates, all with op1 0:
  - (13,0,0,2): user thread ID.
  - (7,0,5,4): prefetch flush.
  - (7,0,10,4): synchronization barrier.
  - (7,0,10,5): memory barrier.
  
  Every other user write leaves all state unchanged and raises `unimpl`.
- R5: With `priv` high, major 0 / op1 0 reads identification word k of the `ID_TABLE` parameter (word k in bits 32k+31..32k). The mapping from (minor, op2) to k is:
  - minor 0: op2 0, 1, 3, 5 → k = 0 to 3.
  - minor 1: op2 0, 1, 2, 4, 5, 6, 7 → k = 4 to 10.
  - minor 2: op2 0 to 4 → k = 11 to 15.
  
  Writes to these words are ignored and flagged.
- R6: With `priv` high, the following coordinates are read/write and read back the last value written:
  - (1,0,0,0..2)
  - (2,0,0,0..2)
  - (3,0,0,0)
  - (5,0,0,0..1)
  - (6,0,0,0..1)
  - (9,0,0,0)
  - (10,0,0,0)
  - (10,0,2,0..1)
  - (13,0,0,0), (13,0,0,1), (13,0,0,4)
  - (15,0,12,0..3)
  - (15,5,5..7,2)
  - (15,7,1,0)
- R7: Coordinate (13,0,0,3) reads `URO_VALUE` in either mode. A privileged write to it is accepted, with `unimpl` low. A user write to it is flagged.
- R8: Command coordinates produce a pulse in the cycle after the write edge, lasting one cycle, and never more than one line at once. A command coordinate that is read returns zero with `unimpl` high.
  - `cache_cmd`, privileged only, for these major-7 writes: (7,0,0,4), (7,0,5,0..2), (7,0,5,6..7), (7,0,6,0..2), (7,0,7,0), (7,0,10,0..2), (7,0,14,0..2).
  - `tlb_cmd`, privileged only, for (8,0,5..7,0..3), (15,5,4,2) and (15,5,4,4).
  - `sync_cmd`, in either mode, for the three barrier coordinates of R4.
- R9: A read of an unmapped coordinate returns zero and raises `unimpl`. A write to one changes nothing and raises no pulse.
- R10: `unimpl` is low when neither strobe is high, and low during any permitted access.
- R11: `rd_data` follows the coordinate and `rd_en` in the same cycle, and is zero while `rd_en` is low. A write becomes visible on `rd_data` right after the edge that commits it.
- R12: With `priv` high, (7,0,4,0) is a read/write physical-address register. It is not readable in user mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe, committed on the rising edge |
| sel_major | input | 4 | Major register number |
| sel_op1 | input | 3 | First opcode field |
| sel_minor | input | 4 | Minor register number |
| sel_op2 | input | 3 | Second opcode field |
| priv | input | 1 | High when the core is in a privileged mode |
| wr_data | input | 32 | Write value |
| rd_data | output | 32 | Read value (combinational) |
| unimpl | output | 1 | Access denied or unmapped in the current mode |
| cache_cmd | output | 1 | One-cycle cache maintenance pulse |
| tlb_cmd | output | 1 | One-cycle TLB maintenance pulse |
| sync_cmd | output | 1 | One-cycle barrier / prefetch-flush pulse |

## Verification
A decode error appears at the ports in the same cycle as the access. The wrong word appears on `rd_data`, or `unimpl` takes the wrong level, because read data and the flag are both combinational. A corrupted or wrongly gated storage word appears on the first read of that coordinate after the bad edge. This includes a user write that leaks into a privileged register. The bench therefore pairs each write with a read-back, including read-backs after denied writes. A misrouted command appears on the pulse lines exactly one cycle after the write edge. It is caught by checking all three lines after every access.

// File: rtl/sysreg_pkg.sv
`timescale 1ns/1ps
package sysreg_pkg;
  localparam int REG_W   = 32;
  localparam int ID_N    = 16;
  localparam int STORE_N = 28;
  localparam int IDX_W   = 5;
  localparam int URW_IDX = 18;

  typedef enum logic [2:0] {
    SK_NONE, SK_IDENT, SK_STORE, SK_UROC, SK_CACHE, SK_TLB, SK_BARRIER
  } slot_kind_e;

  typedef struct packed {
    slot_kind_e       kind;
    logic [IDX_W-1:0] idx;
    logic             user_rd;
    logic             user_wr;
  } slot_t;

  function automatic slot_t mk_slot(slot_kind_e k, int i, bit urd, bit uwr);
    slot_t s;
    s.kind    = k;
    s.idx     = IDX_W'(i);
    s.user_rd = urd;
    s.user_wr = uwr;
    return s;
  endfunction

  function automatic logic [ID_N*REG_W-1:0] id_table_default();
    logic [ID_N*REG_W-1:0] t;
    for (int k = 0; k < ID_N; k++) t[k*REG_W +: REG_W] = 32'h5A00_0000 | REG_W'(k);
    return t;
  endfunction

  // Coordinate map: (major, op1, minor, op2) -> slot class and index
  function automatic slot_t slot_lookup(logic [3:0] ma, logic [2:0] o1,
                                        logic [3:0] mi, logic [2:0] o2);
    slot_t s;
    int    n2;
    n2 = int'(o2);
    s  = mk_slot(SK_NONE, 0, 1'b0, 1'b0);
    if (o1 == 3'd0) begin
      case (ma)
        4'd0: begin
          if (mi == 4'd0) begin
            case (o2)
              3'd0: s = mk_slot(SK_IDENT, 0, 1'b0, 1'b0);
              3'd1: s = mk_slot(SK_IDENT, 1, 1'b0, 1'b0);
              3'd3: s = mk_slot(SK_IDENT, 2, 1'b0, 1'b0);
              3'd5: s = mk_slot(SK_IDENT, 3, 1'b0, 1'b0);
              default: ;
            endcase
          end else if (mi == 4'd1) begin
            if (n2 <= 2)      s = mk_slot(SK_IDENT, 4 + n2, 1'b0, 1'b0);
            else if (n2 >= 4) s = mk_slot(SK_IDENT, 3 + n2, 1'b0, 1'b0);
          end else if (mi == 4'd2 && n2 <= 4) begin
            s = mk_slot(SK_IDENT, 11 + n2, 1'b0, 1'b0);
          end
        end
        4'd1: if (mi == 4'd0 && n2 <= 2) s = mk_slot(SK_STORE, n2, 1'b0, 1'b0);
        4'd2: if (mi == 4'd0 && n2 <= 2) s = mk_slot(SK_STORE, 3 + n2, 1'b0, 1'b0);
        4'd3: if (mi == 4'd0 && n2 == 0) s = mk_slot(SK_STORE, 6, 1'b0, 1'b0);
        4'd5: if (mi == 4'd0 && n2 <= 1) s = mk_slot(SK_STORE, 7 + n2, 1'b0, 1'b0);
        4'd6: if (mi == 4'd0 && n2 <= 1) s = mk_slot(SK_STORE, 9 + n2, 1'b0, 1'b0);
        4'd7: begin
          case (mi)
            4'd0:  if (n2 == 4) s = mk_slot(SK_CACHE, 0, 1'b0, 1'b0);
            4'd4:  if (n2 == 0) s = mk_slot(SK_STORE, 11, 1'b0, 1'b0);
            4'd5: begin
              if (n2 <= 2 || n2 >= 6) s = mk_slot(SK_CACHE, 0, 1'b0, 1'b0);
              else if (n2 == 4)       s = mk_slot(SK_BARRIER, 0, 1'b0, 1'b1);
            end
            4'd6:  if (n2 <= 2) s = mk_slot(SK_CACHE, 0, 1'b0, 1'b0);
            4'd7:  if (n2 == 0) s = mk_slot(SK_CACHE, 0, 1'b0, 1'b0);
            4'd10: begin
              if (n2 <= 2)                 s = mk_slot(SK_CACHE, 0, 1'b0, 1'b0);
              else if (n2 == 4 || n2 == 5) s = mk_slot(SK_BARRIER, 0, 1'b0, 1'b1);
            end
            4'd14: if (n2 <= 2) s = mk_slot(SK_CACHE, 0, 1'b0, 1'b0);
            default: ;
          endcase
        end
        4'd8: if (mi >= 4'd5 && mi <= 4'd7 && n2 <= 3) s = mk_slot(SK_TLB, 0, 1'b0, 1'b0);
        4'd9: if (mi == 4'd0 && n2 == 0) s = mk_slot(SK_STORE, 12, 1'b0, 1'b0);
        4'd10: begin
          if (mi == 4'd0 && n2 == 0)      s = mk_slot(SK_STORE, 13, 1'b0, 1'b0);
          else if (mi == 4'd2 && n2 <= 1) s = mk_slot(SK_STORE, 14 + n2, 1'b0, 1'b0);
        end
        4'd13: begin
          if (mi == 4'd0) begin
            case (o2)
              3'd0: s = mk_slot(SK_STORE, 16, 1'b0, 1'b0);
              3'd1: s = mk_slot(SK_STORE, 17, 1'b0, 1'b0);
              3'd2: s = mk_slot(SK_STORE, URW_IDX, 1'b1, 1'b1);
              3'd3: s = mk_slot(SK_UROC, 0, 1'b1, 1'b0);
              3'd4: s = mk_slot(SK_STORE, 19, 1'b0, 1'b0);
              default: ;
            endcase
          end
        end
        4'd15: if (mi == 4'd12 && n2 <= 3) s = mk_slot(SK_STORE, 20 + n2, 1'b0, 1'b0);
        default: ;
      endcase
    end else if (ma == 4'd15 && o1 == 3'd5) begin
      if (mi == 4'd4 && (n2 == 2 || n2 == 4))
        s = mk_slot(SK_TLB, 0, 1'b0, 1'b0);
      else if (mi >= 4'd5 && mi <= 4'd7 && n2 == 2)
        s = mk_slot(SK_STORE, 24 + int'(mi) - 5, 1'b0, 1'b0);
    end else if (ma == 4'd15 && o1 == 3'd7 && mi == 4'd1 && n2 == 0) begin
      s = mk_slot(SK_STORE, 27, 1'b0, 1'b0);
    end
    return s;
  endfunction
endpackage

// File: rtl/sysreg_decode.sv
`timescale 1ns/1ps
module sysreg_decode
  import sysreg_pkg::*;
(
  input  logic [3:0]       ma,
  input  logic [2:0]       o1,
  input  logic [3:0]       mi,
  input  logic [2:0]       o2,
  input  logic             priv,
  output slot_kind_e       kind,
  output logic [IDX_W-1:0] idx,
  output logic             rd_ok,
  output logic             wr_ok
);
  slot_t s;

  always_comb begin
    s     = slot_lookup(ma, o1, mi, o2);
    kind  = s.kind;
    idx   = s.idx;
    // privileged mode reaches every mapped readable class; user mode only its list
    rd_ok = priv ? (s.kind inside {SK_IDENT, SK_STORE, SK_UROC}) : s.user_rd;
    wr_ok = priv ? (s.kind inside {SK_STORE, SK_UROC, SK_CACHE, SK_TLB, SK_BARRIER})
                 : s.user_wr;
  end
endmodule

// File: rtl/sysreg_bank.sv
`timescale 1ns/1ps
module sysreg_bank #(
  parameter int N  = 28,
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [N*W-1:0] flat;

  for (genvar g = 0; g < N; g++) begin : g_word
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                              q <= '0;
      else if (we && waddr == AW'(g))       q <= wdata;
    end
    assign flat[g*W +: W] = q;
  end

  always_comb begin
    if (int'(raddr) < N) rdata = flat[int'(raddr)*W +: W];
    else                 rdata = '0;
  end

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(flat)); // R6
endmodule

// File: rtl/sysreg_cmd.sv
`timescale 1ns/1ps
module sysreg_cmd
  import sysreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fire,
  input  slot_kind_e kind,
  output logic       cache_cmd,
  output logic       tlb_cmd,
  output logic       sync_cmd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cache_cmd <= 1'b0;
      tlb_cmd   <= 1'b0;
      sync_cmd  <= 1'b0;
    end else begin
      cache_cmd <= fire && (kind == SK_CACHE);
      tlb_cmd   <= fire && (kind == SK_TLB);
      sync_cmd  <= fire && (kind == SK_BARRIER);
    end
  end

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cache_cmd, tlb_cmd, sync_cmd})); // R8
  AST_CMD_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cache_cmd || tlb_cmd || sync_cmd) |-> $past(fire)); // R8
endmodule

// File: rtl/sysctl_regfile.sv
`timescale 1ns/1ps
module sysctl_regfile
  import sysreg_pkg::*;
#(
  parameter logic [ID_N*REG_W-1:0] ID_TABLE  = id_table_default(),
  parameter logic [REG_W-1:0]      URO_VALUE = 32'hFFFF_9000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [3:0]       sel_major,
  input  logic [2:0]       sel_op1,
  input  logic [3:0]       sel_minor,
  input  logic [2:0]       sel_op2,
  input  logic             priv,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             unimpl,
  output logic             cache_cmd,
  output logic             tlb_cmd,
  output logic             sync_cmd
);
  localparam int ID_AW = $clog2(ID_N);

  slot_kind_e       kind;
  logic [IDX_W-1:0] idx;
  logic             rd_ok, wr_ok;
  logic             bank_we;
  logic [REG_W-1:0] bank_q;
  logic [ID_AW-1:0] id_sel;

  sysreg_decode u_dec (
    .ma(sel_major), .o1(sel_op1), .mi(sel_minor), .o2(sel_op2), .priv(priv),
    .kind(kind), .idx(idx), .rd_ok(rd_ok), .wr_ok(wr_ok)
  );

  assign bank_we = wr_en && wr_ok && (kind == SK_STORE);

  sysreg_bank #(.N(STORE_N), .W(REG_W), .AW(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .we(bank_we), .waddr(idx), .wdata(wr_data),
    .raddr(idx), .rdata(bank_q)
  );

  sysreg_cmd u_cmd (
    .clk(clk), .rst(rst), .fire(wr_en && wr_ok), .kind(kind),
    .cache_cmd(cache_cmd), .tlb_cmd(tlb_cmd), .sync_cmd(sync_cmd)
  );

  assign id_sel = idx[ID_AW-1:0];

  always_comb begin
    rd_data = '0;
    if (rd_en && rd_ok) begin
      case (kind)
        SK_IDENT: rd_data = ID_TABLE[int'(id_sel)*REG_W +: REG_W];
        SK_STORE: rd_data = bank_q;
        SK_UROC:  rd_data = URO_VALUE;
        default:  rd_data = '0;
      endcase
    end
  end

  assign unimpl = (rd_en && !rd_ok) || (wr_en && !wr_ok);

  AST_DENIED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && unimpl) |-> rd_data == '0); // R9
  AST_USER_STORE_ONLY_THREAD: assert property (@(posedge clk) disable iff (rst)
    (bank_we && !priv) |-> idx == IDX_W'(URW_IDX)); // R4
  AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    !(rd_en || wr_en) |-> !unimpl); // R10
  AST_NO_STROBE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> rd_data == '0); // R11
endmodule

// File: tb/sysctl_regfile_tb.sv
`timescale 1ns/100ps
module sysctl_regfile_tb_top;
  typedef struct packed {
    logic        p, r, w;
    logic [3:0]  ma;
    logic [2:0]  o1;
    logic [3:0]  mi;
    logic [2:0]  o2;
    logic [31:0] wd, erd;
    logic        eun;
    logic [2:0]  ep;   // {cache, tlb, sync}
    logic [3:0]  rq;
  } vec_t;

  function automatic logic [31:0] bid(int k);
    return 32'h1D00_0000 + 32'(k) * 32'h0001_0101;
  endfunction
  function automatic logic [16*32-1:0] btable();
    logic [16*32-1:0] t;
    for (int k = 0; k < 16; k++) t[k*32 +: 32] = bid(k);
    return t;
  endfunction
  localparam logic [31:0] UROV = 32'hC0DE_7700;

  function automatic vec_t mk(bit p, bit r, bit w, int ma, int o1, int mi, int o2,
                              logic [31:0] wd, logic [31:0] erd, bit eun,
                              logic [2:0] ep, int rq);
    vec_t v;
    v.p = p; v.r = r; v.w = w;
    v.ma = 4'(ma); v.o1 = 3'(o1); v.mi = 4'(mi); v.o2 = 3'(o2);
    v.wd = wd; v.erd = erd; v.eun = eun; v.ep = ep; v.rq = 4'(rq);
    return v;
  endfunction

  localparam int NV = 54;
  localparam vec_t VECS [NV] = '{
    // R6: privileged read/write registers
    mk(1,0,1, 1,0,0,0, 32'h1111_1111, 0, 0, 3'b000, 6),
    mk(1,1,0, 1,0,0,0, 0, 32'h1111_1111, 0, 3'b000, 6),
    mk(1,0,1, 2,0,0,1, 32'h2222_0001, 0, 0, 3'b000, 6),
    mk(1,1,0, 2,0,0,1, 0, 32'h2222_0001, 0, 3'b000, 6),
    mk(1,0,1, 6,0,0,1, 32'h3333_0006, 0, 0, 3'b000, 6),
    mk(1,1,0, 6,0,0,1, 0, 32'h3333_0006, 0, 3'b000, 6),
    mk(1,0,1, 10,0,2,1, 32'h4444_000A, 0, 0, 3'b000, 6),
    mk(1,1,0, 10,0,2,1, 0, 32'h4444_000A, 0, 3'b000, 6),
    mk(1,0,1, 15,0,12,3, 32'h5555_0003, 0, 0, 3'b000, 6),
    mk(1,1,0, 15,0,12,3, 0, 32'h5555_0003, 0, 3'b000, 6),
    mk(1,0,1, 15,5,6,2, 32'h6666_0015, 0, 0, 3'b000, 6),
    mk(1,1,0, 15,5,6,2, 0, 32'h6666_0015, 0, 3'b000, 6),
    mk(1,0,1, 15,7,1,0, 32'h7777_0017, 0, 0, 3'b000, 6),
    mk(1,1,0, 15,7,1,0, 0, 32'h7777_0017, 0, 3'b000, 6),
    mk(1,0,1, 13,0,0,4, 32'h8888_0013, 0, 0, 3'b000, 6),
    // R3: privileged-only thread ID hidden from user mode
    mk(0,1,0, 13,0,0,4, 0, 0, 1, 3'b000, 3),
    mk(1,1,0, 13,0,0,4, 0, 32'h8888_0013, 0, 3'b000, 6),
    // R4 / R3: user thread ID write and read
    mk(0,0,1, 13,0,0,2, 32'h9999_0002, 0, 0, 3'b000, 4),
    mk(0,1,0, 13,0,0,2, 0, 32'h9999_0002, 0, 3'b000, 3),
    mk(1,1,0, 13,0,0,2, 0, 32'h9999_0002, 0, 3'b000, 6),
    // R4: user write to control ignored and flagged
    mk(0,0,1, 1,0,0,0, 32'hDEAD_0000, 0, 1, 3'b000, 4),
    mk(1,1,0, 1,0,0,0, 0, 32'h1111_1111, 0, 3'b000, 4),
    mk(0,1,0, 1,0,0,0, 0, 0, 1, 3'b000, 3),
    // R7: constant thread ID
    mk(0,1,0, 13,0,0,3, 0, UROV, 0, 3'b000, 7),
    mk(1,0,1, 13,0,0,3, 32'h1234_5678, 0, 0, 3'b000, 7),
    mk(1,1,0, 13,0,0,3, 0, UROV, 0, 3'b000, 7),
    mk(0,0,1, 13,0,0,3, 32'h1234_5678, 0, 1, 3'b000, 7),
    // R5: identification words
    mk(1,1,0, 0,0,0,0, 0, bid(0), 0, 3'b000, 5),
    mk(1,1,0, 0,0,0,5, 0, bid(3), 0, 3'b000, 5),
    mk(1,1,0, 0,0,1,4, 0, bid(7), 0, 3'b000, 5),
    mk(1,1,0, 0,0,2,4, 0, bid(15), 0, 3'b000, 5),
    mk(1,1,0, 0,0,0,2, 0, 0, 1, 3'b000, 9),
    mk(1,0,1, 0,0,0,0, 32'hFFFF_FFFF, 0, 1, 3'b000, 5),
    mk(1,1,0, 0,0,0,0, 0, bid(0), 0, 3'b000, 5),
    mk(0,1,0, 0,0,0,0, 0, 0, 1, 3'b000, 3),
    // R2: every field takes part in the match
    mk(1,1,0, 1,1,0,0, 0, 0, 1, 3'b000, 2),
    mk(1,1,0, 1,0,1,0, 0, 0, 1, 3'b000, 2),
    mk(1,0,1, 1,0,0,3, 32'hBAD0_0000, 0, 1, 3'b000, 2),
    mk(1,1,0, 13,1,0,2, 0, 0, 1, 3'b000, 2),
    // R8: command pulses
    mk(1,0,1, 7,0,5,0, 0, 0, 0, 3'b100, 8),
    mk(1,0,1, 7,0,14,2, 0, 0, 0, 3'b100, 8),
    mk(1,0,1, 8,0,6,3, 0, 0, 0, 3'b010, 8),
    mk(1,0,1, 15,5,4,4, 0, 0, 0, 3'b010, 8),
    mk(0,0,1, 7,0,10,5, 0, 0, 0, 3'b001, 8),
    mk(1,0,1, 7,0,5,4, 0, 0, 0, 3'b001, 8),
    mk(0,0,1, 8,0,5,0, 0, 0, 1, 3'b000, 4),
    mk(0,0,1, 7,0,5,0, 0, 0, 1, 3'b000, 4),
    mk(1,1,0, 7,0,5,0, 0, 0, 1, 3'b000, 8),
    mk(1,0,1, 8,0,5,4, 0, 0, 1, 3'b000, 9),
    // R12: physical-address register
    mk(1,0,1, 7,0,4,0, 32'hABCD_1234, 0, 0, 3'b000, 12),
    mk(1,1,0, 7,0,4,0, 0, 32'hABCD_1234, 0, 3'b000, 12),
    mk(0,1,0, 7,0,4,0, 0, 0, 1, 3'b000, 12),
    // R9 unmapped, R10 idle
    mk(1,1,0, 4,0,0,0, 0, 0, 1, 3'b000, 9),
    mk(1,0,0, 1,0,0,0, 0, 0, 0, 3'b000, 10)
  };

  logic clk = 1'b0, rst = 1'b1;
  logic rd_en = 0, wr_en = 0, priv = 0;
  logic [3:0] sel_major = 0, sel_minor = 0;
  logic [2:0] sel_op1 = 0, sel_op2 = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic unimpl, cache_cmd, tlb_cmd, sync_cmd;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sysctl_regfile #(.ID_TABLE(btable()), .URO_VALUE(UROV)) dut_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
    .sel_major(sel_major), .sel_op1(sel_op1), .sel_minor(sel_minor), .sel_op2(sel_op2),
    .priv(priv), .wr_data(wr_data), .rd_data(rd_data), .unimpl(unimpl),
    .cache_cmd(cache_cmd), .tlb_cmd(tlb_cmd), .sync_cmd(sync_cmd)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(vec_t v, string tag);
    @(negedge clk);
    priv = v.p; rd_en = v.r; wr_en = v.w;
    sel_major = v.ma; sel_op1 = v.o1; sel_minor = v.mi; sel_op2 = v.o2; wr_data = v.wd;
    #0.5;
    if (v.r) check(rd_data == v.erd, {tag, " rd_data"}, rd_data, v.erd);
    check(unimpl == v.eun, {tag, " unimpl"}, 32'(unimpl), 32'(v.eun));
    @(posedge clk);
    #1;
    check({cache_cmd, tlb_cmd, sync_cmd} == v.ep, {tag, " pulses"},
          32'({cache_cmd, tlb_cmd, sync_cmd}), 32'(v.ep));
  endtask

  task automatic idle();
    @(negedge clk);
    rd_en = 0; wr_en = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1: reset state of storage and pulses
    apply(mk(1,1,0, 1,0,0,0, 0, 0, 0, 3'b000, 1), "R1 control after reset");
    apply(mk(1,1,0, 2,0,0,0, 0, 0, 0, 3'b000, 1), "R1 tbase0 after reset");
    apply(mk(1,1,0, 13,0,0,2, 0, 0, 0, 3'b000, 1), "R1 thread after reset");
    apply(mk(1,1,0, 15,5,7,2, 0, 0, 0, 3'b000, 1), "R1 lockdown attr after reset");

    for (int i = 0; i < NV; i++)
      apply(VECS[i], $sformatf("R%0d vec%0d", VECS[i].rq, i));

    // R11: combinational read sees old value before the edge, new value after
    @(negedge clk);
    priv = 1; rd_en = 1; wr_en = 1;
    sel_major = 1; sel_op1 = 0; sel_minor = 0; sel_op2 = 0; wr_data = 32'hCAFE_0001;
    #0.5;
    check(rd_data == 32'h1111_1111, "R11 before edge", rd_data, 32'h1111_1111);
    @(posedge clk);
    #1;
    check(rd_data == 32'hCAFE_0001, "R11 after edge", rd_data, 32'hCAFE_0001);
    idle();
    #0.5;
    check(rd_data == 32'h0, "R11 no read strobe", rd_data, 32'h0);

    // R1: reset in mid-run clears stored values
    @(negedge clk) rst = 1;
    @(posedge clk);
    @(negedge clk) rst = 0;
    apply(mk(1,1,0, 1,0,0,0, 0, 0, 0, 3'b000, 1), "R1 control after mid reset");
    apply(mk(0,1,0, 13,0,0,2, 0, 0, 0, 3'b000, 1), "R1 thread after mid reset");
    apply(mk(1,1,0, 7,0,4,0, 0, 0, 0, 3'b000, 1), "R1 phys after mid reset");
    idle();

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule